// File: doc/BRIEF.md
# Memory Tag Check Access Classifier

This block sits beside the load/store path of a core that supports memory tagging. For every data access it decides whether the access must be tag-checked. The decision uses the access class, the modify-privilege state, the tagging mode and translation state of the effective privilege, and the tag bit of the first-stage page. When a checked access reports a tag mismatch, the block raises a software-check exception request. The request carries the handler level, the trap value and the guest-virtual-address flag.

The block also holds two override bits: one for the machine level and one for the hypervisor level. Each bit records the tag bit of the code page that held a trapping instruction. A trap strobe updates the bit only when it carries a nonzero transformed-instruction value. While an override bit is set, the matching class of accesses is exempt from checking. For the machine bit these are loads and stores under modify-privilege. For the hypervisor bit these are hypervisor virtual-machine loads and stores. Each bit is presented at its architectural position in a status-word slice, so that the status register logic can OR it in.

All outputs are registered. The verdict for an access presented in cycle N appears after the clock edge that ends cycle N. An override captured in cycle N applies to accesses from cycle N+1 onward.

Top module: `tagchk_gate`

## Requirements
- R1: An access of class 3 (hypervisor execute-permission load) is never checked, whatever the other inputs are.
- R2: An access of class 1 (hypervisor load) or class 2 (hypervisor store) is unchecked while the hypervisor override bit is 1. While that bit is 0, the access follows the normal checking rules.
- R3: An access of class 0 (ordinary load/store) with `mprv` = 1 is unchecked while the machine override bit is 1. With `mprv` = 0, the machine override bit has no effect.
- R4: An access is checked only if all four of these hold: `paging_on` = 1, `tag_on` = 1, `page_tag` = 1, and the selected tagging mode is not 2'b00.
- R5: The selected tagging mode is `vu_mode` when `env_hyp_user` = 1, `eff_virt` = 1 and `eff_priv` = 2'b00 (user). In every other case it is `base_mode`.
- R6: A checked access of class 1 or 2 with `tag_mismatch` = 1 raises `exc_req` with `exc_to_m` = 0 (supervisor handler), `exc_tval` = 4 and `exc_gva` = 1.
- R7: A checked access of class 0 with `tag_mismatch` = 1 raises `exc_req` with `exc_to_m` = 1 (machine handler), `exc_tval` = 4 and `exc_gva` = 0.
- R8: `exc_req` is high only in the cycle after a checked access that had `tag_mismatch` = 1. When `exc_req` is low, `exc_to_m`, `exc_gva` and `exc_tval` are all 0.
- R9: `m_trap` with a nonzero `m_tinst` loads `m_code_tag` into the machine override bit, shown at bit 40 of `mstat_tag_bits`. A zero `m_tinst` leaves the bit unchanged.
- R10: `h_trap` with a nonzero `h_tinst` loads `h_code_tag` into the hypervisor override bit, shown at bit 10 of `hstat_tag_bits`. A zero `h_tinst` leaves the bit unchanged.
- R11: After reset, every output is 0, including both override bits.
- R12: An access in the same cycle as an override capture is judged with the override value that held before the capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A load/store is presented this cycle |
| acc_class | input | 2 | 0 ordinary, 1 hyp load, 2 hyp store, 3 hyp exec-permission load |
| mprv | input | 1 | Modify-privilege state is active |
| eff_priv | input | 2 | Effective privilege level (0 user, 1 supervisor, 3 machine) |
| eff_virt | input | 1 | Effective privilege is virtualized |
| env_hyp_user | input | 1 | Execution environment is hypervisor-user |
| base_mode | input | 2 | Tagging mode of the effective privilege |
| vu_mode | input | 2 | Tagging mode for virtual-user effective privilege |
| paging_on | input | 1 | Page translation enabled for effective privilege |
| tag_on | input | 1 | Tagging enabled for effective privilege |
| page_tag | input | 1 | First-stage page tag bit |
| tag_mismatch | input | 1 | Tag comparison failed for this access |
| m_trap | input | 1 | Trap to machine level taken |
| m_tinst | input | XLEN | Transformed instruction value written with that trap |
| m_code_tag | input | 1 | Code-page tag bit of the trapping instruction |
| h_trap | input | 1 | Trap to hypervisor-supervisor level taken |
| h_tinst | input | XLEN | Transformed instruction value written with that trap |
| h_code_tag | input | 1 | Guest-stage code-page tag bit of the trapping instruction |
| chk_q | output | 1 | Previous access was checked |
| exc_req | output | 1 | Software-check exception request pulse |
| exc_to_m | output | 1 | 1 machine handler, 0 supervisor handler |
| exc_tval | output | XLEN | Trap value (4 with a request) |
| exc_gva | output | 1 | Guest virtual address flag |
| mstat_tag_bits | output | XLEN | Machine override bit at bit 40 |
| hstat_tag_bits | output | XLEN | Hypervisor override bit at bit 10 |

## Verification
Override capture and access classification can fall in the same cycle. A trap that changes an override bit can share a cycle with an access whose verdict depends on that bit. The bench provokes this by raising `m_trap` with a nonzero value and a new tag bit while it presents a modify-privilege load that has a mismatch. The check passes if that access is judged with the old override and the next such access with the new one. A long stretch of random stimulus also strikes this collision for both trap sources, and a behavioural model judges those cycles.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    typedef enum logic [1:0] {
        ACC_PLAIN    = 2'd0,
        ACC_HYP_LD   = 2'd1,
        ACC_HYP_ST   = 2'd2,
        ACC_HYP_EXEC = 2'd3
    } acc_class_e;

    localparam logic [1:0] PRIV_USER = 2'd0;
    localparam logic [1:0] MODE_OFF  = 2'b00;

    typedef struct packed {
        logic chk;
        logic exc;
        logic to_m;
        logic gva;
    } verdict_t;

endpackage

// File: rtl/tagchk_mode_pick.sv
module tagchk_mode_pick
    import tagchk_pkg::*;
(
    input  logic       env_hyp_user,
    input  logic       eff_virt,
    input  logic [1:0] eff_priv,
    input  logic [1:0] base_mode,
    input  logic [1:0] vu_mode,
    output logic [1:0] mode
);
    logic use_vu;

    always_comb begin
        use_vu = env_hyp_user && eff_virt && (eff_priv == PRIV_USER);
        mode   = use_vu ? vu_mode : base_mode;
    end
endmodule

// File: rtl/tagchk_candidate.sv
module tagchk_candidate
    import tagchk_pkg::*;
(
    input  logic [1:0] acc_class,
    input  logic       mprv,
    input  logic       hyp_ovr,
    input  logic       mach_ovr,
    output logic       cand,
    output logic       is_hyp
);
    acc_class_e cls;

    always_comb begin
        cls    = acc_class_e'(acc_class);
        cand   = 1'b0;
        is_hyp = 1'b0;
        unique case (cls)
            ACC_PLAIN: begin
                cand = mprv ? !mach_ovr : 1'b1;
            end
            ACC_HYP_LD, ACC_HYP_ST: begin
                cand   = !hyp_ovr;
                is_hyp = 1'b1;
            end
            ACC_HYP_EXEC: begin
                cand   = 1'b0;
                is_hyp = 1'b1;
            end
            default: begin
                cand   = 1'b0;
                is_hyp = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tagchk_tag_latch.sv
module tagchk_tag_latch #(
    parameter int XLEN    = 64,
    parameter int BIT_POS = 40
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trap,
    input  logic [XLEN-1:0] tinst,
    input  logic            code_tag,
    output logic            ovr,
    output logic [XLEN-1:0] word
);
    logic ovr_d, ovr_q;

    always_comb begin
        ovr_d = ovr_q;
        if (trap && (tinst != '0)) begin
            ovr_d = code_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= ovr_d;
        end
    end

    assign ovr = ovr_q;

    for (genvar i = 0; i < XLEN; i++) begin : g_word
        if (i == BIT_POS) begin : g_hit
            assign word[i] = ovr_q;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end
endmodule

// File: rtl/tagchk_gate.sv
module tagchk_gate
    import tagchk_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int MSTAT_POS  = 40,
    parameter int HSTAT_POS  = 10,
    parameter int TVAL_CODE  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic [1:0]      acc_class,
    input  logic            mprv,
    input  logic [1:0]      eff_priv,
    input  logic            eff_virt,
    input  logic            env_hyp_user,
    input  logic [1:0]      base_mode,
    input  logic [1:0]      vu_mode,
    input  logic            paging_on,
    input  logic            tag_on,
    input  logic            page_tag,
    input  logic            tag_mismatch,
    input  logic            m_trap,
    input  logic [XLEN-1:0] m_tinst,
    input  logic            m_code_tag,
    input  logic            h_trap,
    input  logic [XLEN-1:0] h_tinst,
    input  logic            h_code_tag,
    output logic            chk_q,
    output logic            exc_req,
    output logic            exc_to_m,
    output logic [XLEN-1:0] exc_tval,
    output logic            exc_gva,
    output logic [XLEN-1:0] mstat_tag_bits,
    output logic [XLEN-1:0] hstat_tag_bits
);
    localparam int NSRC = 2;
    localparam int SRC_M = 0;
    localparam int SRC_H = 1;
    localparam logic [XLEN-1:0] TVAL_WORD = XLEN'(TVAL_CODE);

    logic [1:0] mode;
    logic       cand;
    logic       is_hyp;

    logic [NSRC-1:0]           src_trap;
    logic [NSRC-1:0][XLEN-1:0] src_tinst;
    logic [NSRC-1:0]           src_tag;
    logic [NSRC-1:0]           src_ovr;
    logic [NSRC-1:0][XLEN-1:0] src_word;

    verdict_t v_d, v_q;

    assign src_trap[SRC_M]  = m_trap;
    assign src_tinst[SRC_M] = m_tinst;
    assign src_tag[SRC_M]   = m_code_tag;
    assign src_trap[SRC_H]  = h_trap;
    assign src_tinst[SRC_H] = h_tinst;
    assign src_tag[SRC_H]   = h_code_tag;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        localparam int POS = (s == SRC_M) ? MSTAT_POS : HSTAT_POS;
        tagchk_tag_latch #(
            .XLEN    (XLEN),
            .BIT_POS (POS)
        ) u_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .trap     (src_trap[s]),
            .tinst    (src_tinst[s]),
            .code_tag (src_tag[s]),
            .ovr      (src_ovr[s]),
            .word     (src_word[s])
        );
    end

    tagchk_mode_pick u_mode (
        .env_hyp_user (env_hyp_user),
        .eff_virt     (eff_virt),
        .eff_priv     (eff_priv),
        .base_mode    (base_mode),
        .vu_mode      (vu_mode),
        .mode         (mode)
    );

    tagchk_candidate u_cand (
        .acc_class (acc_class),
        .mprv      (mprv),
        .hyp_ovr   (src_ovr[SRC_H]),
        .mach_ovr  (src_ovr[SRC_M]),
        .cand      (cand),
        .is_hyp    (is_hyp)
    );

    always_comb begin
        v_d      = '0;
        v_d.chk  = acc_valid && cand && (mode != MODE_OFF)
                   && paging_on && tag_on && page_tag;
        v_d.exc  = v_d.chk && tag_mismatch;
        v_d.to_m = v_d.exc && !is_hyp;
        v_d.gva  = v_d.exc && is_hyp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0;
        end else begin
            v_q <= v_d;
        end
    end

    assign chk_q          = v_q.chk;
    assign exc_req        = v_q.exc;
    assign exc_to_m       = v_q.to_m;
    assign exc_gva        = v_q.gva;
    assign exc_tval       = v_q.exc ? TVAL_WORD : '0;
    assign mstat_tag_bits = src_word[SRC_M];
    assign hstat_tag_bits = src_word[SRC_H];
endmodule

// File: rtl/tagchk_gate_chk.sv
module tagchk_gate_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic [1:0]      acc_class,
    input logic            mprv,
    input logic            paging_on,
    input logic            tag_mismatch,
    input logic            m_trap,
    input logic [XLEN-1:0] m_tinst,
    input logic            h_trap,
    input logic [XLEN-1:0] h_tinst,
    input logic            chk_q,
    input logic            exc_req,
    input logic            exc_to_m,
    input logic [XLEN-1:0] exc_tval,
    input logic            exc_gva,
    input logic [XLEN-1:0] mstat_tag_bits,
    input logic [XLEN-1:0] hstat_tag_bits
);
    AST_EXEC_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_class == 2'd3) |=> !chk_q); // R1

    AST_NEED_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !paging_on) |=> !chk_q); // R4

    AST_HYP_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_class == 2'd1 || acc_class == 2'd2))
        |=> (!exc_req || (!exc_to_m && exc_gva && exc_tval == XLEN'(4)))); // R6

    AST_PLAIN_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_class == 2'd0)
        |=> (!exc_req || (exc_to_m && !exc_gva && exc_tval == XLEN'(4)))); // R7

    AST_EXC_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || !tag_mismatch) |=> !exc_req); // R8

    AST_IDLE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (!exc_to_m && !exc_gva && exc_tval == '0)); // R8

    AST_M_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_trap && m_tinst != '0) |=> $stable(mstat_tag_bits)); // R9

    AST_H_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_trap && h_tinst != '0) |=> $stable(hstat_tag_bits)); // R10
endmodule

bind tagchk_gate tagchk_gate_chk #(.XLEN(XLEN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_class      (acc_class),
    .mprv           (mprv),
    .paging_on      (paging_on),
    .tag_mismatch   (tag_mismatch),
    .m_trap         (m_trap),
    .m_tinst        (m_tinst),
    .h_trap         (h_trap),
    .h_tinst        (h_tinst),
    .chk_q          (chk_q),
    .exc_req        (exc_req),
    .exc_to_m       (exc_to_m),
    .exc_tval       (exc_tval),
    .exc_gva        (exc_gva),
    .mstat_tag_bits (mstat_tag_bits),
    .hstat_tag_bits (hstat_tag_bits)
);

// File: tb/sim_tagchk_gate.sv
`timescale 1ns/1ps
module sim_tagchk_gate;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            acc_valid;
    logic [1:0]      acc_class;
    logic            mprv;
    logic [1:0]      eff_priv;
    logic            eff_virt;
    logic            env_hyp_user;
    logic [1:0]      base_mode;
    logic [1:0]      vu_mode;
    logic            paging_on, tag_on, page_tag, tag_mismatch;
    logic            m_trap, m_code_tag, h_trap, h_code_tag;
    logic [XLEN-1:0] m_tinst, h_tinst;
    logic            chk_q, exc_req, exc_to_m, exc_gva;
    logic [XLEN-1:0] exc_tval, mstat_tag_bits, hstat_tag_bits;

    int n_run  = 0;
    int n_fail = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    bit              e_chk, e_exc, e_tom, e_gva;
    bit              m_ovr, h_ovr;

    always #2.5 clk = ~clk;

    tagchk_gate #(.XLEN(XLEN)) u0 (.*);

    always @(posedge clk) begin
        if (!rst_n) begin
            e_chk = 0; e_exc = 0; e_tom = 0; e_gva = 0;
            m_ovr = 0; h_ovr = 0;
        end else begin
            logic [1:0] md;
            bit cand;
            if (env_hyp_user && eff_virt && eff_priv == 2'd0) md = vu_mode;
            else md = base_mode;
            if (acc_class == 2'd3) cand = 0;
            else if (acc_class != 2'd0) cand = !h_ovr;
            else if (mprv) cand = !m_ovr;
            else cand = 1;
            e_chk = acc_valid && cand && md != 2'b00 && paging_on && tag_on && page_tag;
            e_exc = e_chk && tag_mismatch;
            e_tom = e_exc && acc_class == 2'd0;
            e_gva = e_exc && acc_class != 2'd0;
            if (m_trap && m_tinst != 0) m_ovr = m_code_tag;
            if (h_trap && h_tinst != 0) h_ovr = h_code_tag;
        end
        started = 1;
    end

    task automatic check(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model comparison on every cycle, away from the rising edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R4 chk", chk_q, e_chk);
            check("R8 exc", exc_req, e_exc);
            check("R7 to_m", exc_to_m, e_tom);
            check("R6 gva", exc_gva, e_gva);
            check("R8 tval", exc_tval, e_exc ? 64'd4 : 64'd0);
            check("R9 mstat", mstat_tag_bits, 64'(m_ovr) << 40);
            check("R10 hstat", hstat_tag_bits, 64'(h_ovr) << 10);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        acc_valid = 0; tag_mismatch = 0; m_trap = 0; h_trap = 0;
        m_tinst = 0; h_tinst = 0; m_code_tag = 0; h_code_tag = 0;
    endtask

    task automatic access(logic [1:0] cls, logic mp, logic mm);
        acc_valid = 1; acc_class = cls; mprv = mp; tag_mismatch = mm;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; idle(); acc_class = 0; mprv = 0; eff_priv = 0; eff_virt = 0;
        env_hyp_user = 0; base_mode = 0; vu_mode = 0;
        paging_on = 0; tag_on = 0; page_tag = 0;
        repeat (3) tick();
        rst_n = 1;
        tick();
        check("R11 chk reset", chk_q, 0);
        check("R11 exc reset", exc_req, 0);
        check("R11 tval reset", exc_tval, 0);
        check("R11 mstat reset", mstat_tag_bits, 0);
        check("R11 hstat reset", hstat_tag_bits, 0);

        paging_on = 1; tag_on = 1; page_tag = 1; base_mode = 2'd1;

        // R7 ordinary mismatch goes to machine handler
        access(2'd0, 0, 1); tick();
        check("R7 chk", chk_q, 1); check("R7 exc", exc_req, 1);
        check("R7 to_m", exc_to_m, 1); check("R7 gva", exc_gva, 0);
        check("R7 tval", exc_tval, 4);
        idle(); tick();
        check("R8 pulse ends", exc_req, 0);

        // R1 exec-permission class never checked
        access(2'd3, 0, 1); tick();
        check("R1 chk", chk_q, 0); check("R1 exc", exc_req, 0);

        // R6 hypervisor load and store
        access(2'd1, 0, 1); tick();
        check("R6 ld exc", exc_req, 1); check("R6 ld to_m", exc_to_m, 0);
        check("R6 ld gva", exc_gva, 1); check("R6 ld tval", exc_tval, 4);
        access(2'd2, 0, 1); tick();
        check("R6 st exc", exc_req, 1); check("R6 st gva", exc_gva, 1);

        // R10 / R2 hypervisor override
        idle(); h_trap = 1; h_tinst = 64'h5; h_code_tag = 1; tick();
        check("R10 set", hstat_tag_bits, 64'h400);
        idle(); access(2'd1, 0, 1); tick();
        check("R2 ld exempt", chk_q, 0); check("R2 no exc", exc_req, 0);
        idle(); h_trap = 1; h_tinst = 0; h_code_tag = 0; tick();
        check("R10 zero keeps", hstat_tag_bits, 64'h400);
        idle(); access(2'd2, 0, 0); tick();
        check("R2 st exempt", chk_q, 0);
        idle(); h_trap = 1; h_tinst = 64'h1; h_code_tag = 0; tick();
        check("R10 clear", hstat_tag_bits, 0);
        idle(); access(2'd2, 0, 0); tick();
        check("R2 st checked", chk_q, 1);

        // R9 / R3 machine override
        idle(); m_trap = 1; m_tinst = 64'h7; m_code_tag = 1; tick();
        check("R9 set", mstat_tag_bits, 64'h1 << 40);
        idle(); access(2'd0, 1, 1); tick();
        check("R3 mprv exempt", chk_q, 0); check("R3 no exc", exc_req, 0);
        access(2'd0, 0, 0); tick();
        check("R3 no mprv checked", chk_q, 1);
        access(2'd1, 0, 0); tick();
        check("R3 hyp unaffected", chk_q, 1);
        idle(); m_trap = 1; m_tinst = 0; m_code_tag = 0; tick();
        check("R9 zero keeps", mstat_tag_bits, 64'h1 << 40);

        // R12 capture and access in one cycle
        idle(); access(2'd0, 1, 1); m_trap = 1; m_tinst = 64'h3; m_code_tag = 0; tick();
        check("R12 old ovr used", chk_q, 0);
        check("R12 ovr updated", mstat_tag_bits, 0);
        idle(); access(2'd0, 1, 1); tick();
        check("R12 new ovr used", chk_q, 1); check("R12 exc", exc_to_m, 1);

        // R4 each enable alone
        idle(); page_tag = 0; access(2'd0, 0, 1); tick();
        check("R4 page_tag", chk_q, 0);
        page_tag = 1; paging_on = 0; tick();
        check("R4 paging", chk_q, 0);
        paging_on = 1; tag_on = 0; tick();
        check("R4 tag_on", chk_q, 0); check("R8 no exc unchecked", exc_req, 0);
        tag_on = 1; base_mode = 0; tick();
        check("R4 mode off", chk_q, 0);

        // R5 mode selection
        env_hyp_user = 1; eff_virt = 1; eff_priv = 0; vu_mode = 0; base_mode = 1;
        access(2'd1, 0, 0); tick();
        check("R5 vu off", chk_q, 0);
        vu_mode = 2; base_mode = 0; tick();
        check("R5 vu on", chk_q, 1);
        eff_priv = 1; tick();
        check("R5 base used", chk_q, 0);
        env_hyp_user = 0; eff_virt = 0; base_mode = 1;

        // R8 mismatch without valid
        idle(); tag_mismatch = 1; tick();
        check("R8 invalid", exc_req, 0);

        // random sweep judged by the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            acc_valid = r[0]; acc_class = r[2:1]; mprv = r[3];
            eff_priv = r[5:4]; eff_virt = r[6]; env_hyp_user = r[7];
            base_mode = r[9:8]; vu_mode = r[11:10];
            paging_on = r[12] | r[13]; tag_on = r[14] | r[15]; page_tag = r[16] | r[17];
            tag_mismatch = r[18];
            m_trap = r[19] & r[20]; m_tinst = {63'd0, r[21]}; m_code_tag = r[22];
            h_trap = r[23] & r[24]; h_tinst = {r[25], 63'd0}; h_code_tag = r[26];
            tick();
        end
        idle(); tick();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule